// File: doc/BRIEF.md
# Dual H-Bridge Current Chopper with Selectable Decay

This block produces the gate commands for two H-bridges, one for each winding of a two-phase motor. Each bridge has two half bridges, and each half bridge has one high-side and one low-side gate. A free-running period counter gives a fixed chopping frequency. At every wrap of that counter, each bridge drives its diagonal in the commanded direction. It keeps driving until an external comparator reports that the current sensed on the high side has passed the limit.

When the on phase ends, the bridge lets the winding current decay in one of four ways, chosen by a 2-bit mode code:
- slow recirculation through both high sides;
- fast decay through the reverse diagonal;
- fast for a fixed number of cycles, then slow;
- fast until a low-side under-run comparator fires, then slow.

An auto bit replaces the mode code with a rule based on whether the new current target rose. Every change of conduction pattern passes through a dead interval with all four gates of the bridge off. The length of that interval is set by a slew code. The analog comparators, the reference DACs and the gate drivers are outside the block.

Top module: `dual_bridge_chopper`

## Requirements
- R1: After the synchronous reset, every gate is low, and it stays low until the first wrap of the period counter.
- R2: In the on phase, phase p drives half bridges 2p (side A) and 2p+1 (side B).
  - With direction 1, high side A and low side B are on. With direction 0, high side B and low side A are on.
  - The on phase holds while the high-side comparator stays low.
- R3: A high-side comparator assertion during the on phase ends it. All four gates of that bridge are then low for exactly 4 << slew cycles (slew code 0..3 gives 4, 8, 16 or 32) before the decay pattern appears.
- R4: Slow decay (code 00) drives both high sides with both low sides off.
- R5: Fast decay (code 01) drives the reverse diagonal of the on phase. It keeps that pattern until the next period, whatever the low-side comparator does.
- R6: Mixed-fixed decay (code 10) gives fast decay for fix_len cycles, with 0 treated as 1. It then gives a dead interval of 4 << slew cycles, then slow decay.
- R7: Mixed-threshold decay (code 11) gives fast decay until the low-side under-run comparator is high at a clock edge. It then gives a dead interval of 4 << slew cycles, then slow decay.
- R8: With auto set, the decay is chosen when the on phase ends, as follows:
  - limit_up high selects slow decay;
  - otherwise the programmed code is used, except that code 00 becomes fast decay.
- R9: The PER_W-bit period counter starts a new on phase at each wrap. From a decay pattern the bridge first passes through a full dead interval of 4 << slew cycles. Consecutive on-phase starts are 2^PER_W cycles apart.
- R10: all_off drives every gate low at the next clock edge and returns both bridges to idle. The next on phase starts at the following period wrap, with no dead interval.
- R11: The high-side and low-side gates of the same half bridge are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| all_off | input | 1 | Synchronous force of all gates low and return to idle |
| decay_mode | input | 2 | 00 slow, 01 fast, 10 mixed-fixed, 11 mixed-threshold |
| auto_en | input | 1 | Selects auto decay choice |
| slew | input | 2 | Dead interval code, 4 << slew cycles |
| fix_len | input | FIX_W | Fast-interval length for mixed-fixed decay |
| dir | input | NPH | Direction per phase |
| limit_up | input | NPH | Per phase: new current target is higher than the previous one |
| hs_over | input | NPH | Per phase: high-side current above limit |
| ls_under | input | NPH | Per phase: low-side current below limit |
| hs_gate | output | 2*NPH | High-side gate per half bridge |
| ls_gate | output | 2*NPH | Low-side gate per half bridge |

## Verification
The bench builds the block with PER_W=7, DT_BASE=4 and FIX_W=4. With a 128-cycle period, a full sequence fits inside one period even at the longest dead interval: dead, on, dead, fixed fast interval, dead, slow. The bench sweeps every combination of slew code, decay code, auto bit, limit_up and direction. For each one it measures the dead-interval lengths, the fixed fast length and the spacing between on-phase starts in cycles, and compares them with values computed from the slew code and fix_len. A zero fix_len at slew code 0 reaches the one-cycle fast case. A final all_off pulse confirms that the block restarts at the next wrap with no dead interval.

// File: rtl/chop_pkg.sv
package chop_pkg;

  typedef enum logic [1:0] {
    DK_SLOW   = 2'b00,
    DK_FAST   = 2'b01,
    DK_MIXFIX = 2'b10,
    DK_MIXTH  = 2'b11
  } decay_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ON,
    ST_DEAD,
    ST_FAST,
    ST_SLOW
  } chop_st_e;

  // Decay actually applied once the on phase ends.
  function automatic decay_e pick_decay(decay_e mode, logic auto_sel, logic rose);
    if (!auto_sel) return mode;
    if (rose) return DK_SLOW;
    return (mode == DK_SLOW) ? DK_FAST : mode;
  endfunction

endpackage

// File: rtl/chop_period.sv
module chop_period #(
  parameter int PER_W = 8
) (
  input  logic clk,
  input  logic rst,
  output logic wrap
);
  logic [PER_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  assign wrap = (cnt == {PER_W{1'b1}});

endmodule

// File: rtl/chop_phase.sv
module chop_phase
  import chop_pkg::*;
#(
  parameter int DT_BASE = 4,
  parameter int FIX_W   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             all_off,
  input  logic             wrap,
  input  decay_e           mode,
  input  logic             auto_en,
  input  logic [1:0]       slew,
  input  logic [FIX_W-1:0] fix_len,
  input  logic             dir,
  input  logic             limit_up,
  input  logic             hs_over,
  input  logic             ls_under,
  output logic [1:0]       hs_q,   // bit0 side A, bit1 side B
  output logic [1:0]       ls_q
);
  localparam int DTW = $clog2(DT_BASE * 8);

  chop_st_e         st, st_n, tgt, tgt_n;
  decay_e           dk, dk_n, pick;
  logic             dq, dq_n, pend, pend_n;
  logic [DTW-1:0]   dcnt, dcnt_n, dload;
  logic [FIX_W-1:0] fcnt, fcnt_n, fix_eff;
  logic [1:0]       hs_n, ls_n;
  logic             fix_done;

  always_comb begin
    dload    = DTW'((DT_BASE << slew) - 1);
    fix_eff  = (fix_len == '0) ? FIX_W'(1) : fix_len;
    fix_done = ((FIX_W+1)'(fcnt) + (FIX_W+1)'(1)) >= (FIX_W+1)'(fix_eff);
    pick     = pick_decay(mode, auto_en, limit_up);
  end

  always_comb begin
    st_n   = st;
    tgt_n  = tgt;
    dk_n   = dk;
    dq_n   = dq;
    dcnt_n = dcnt;
    fcnt_n = fcnt;
    pend_n = pend | wrap;
    if (all_off) begin
      st_n   = ST_IDLE;
      pend_n = 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (wrap) begin
          st_n   = ST_ON;
          dq_n   = dir;
          pend_n = 1'b0;
        end
        ST_ON: if (hs_over) begin
          dk_n   = pick;
          st_n   = ST_DEAD;
          tgt_n  = (pick == DK_SLOW) ? ST_SLOW : ST_FAST;
          dcnt_n = dload;
        end else begin
          pend_n = 1'b0;
        end
        ST_DEAD: if (dcnt == '0) begin
          st_n   = tgt;
          fcnt_n = '0;
          if (tgt == ST_ON) begin
            dq_n   = dir;
            pend_n = 1'b0;
          end
        end else begin
          dcnt_n = dcnt - 1'b1;
        end
        ST_FAST: if (pend || wrap) begin
          st_n   = ST_DEAD;
          tgt_n  = ST_ON;
          dcnt_n = dload;
        end else if ((dk == DK_MIXFIX && fix_done) || (dk == DK_MIXTH && ls_under)) begin
          st_n   = ST_DEAD;
          tgt_n  = ST_SLOW;
          dcnt_n = dload;
        end else if (dk == DK_MIXFIX) begin
          fcnt_n = fcnt + 1'b1;
        end
        ST_SLOW: if (pend || wrap) begin
          st_n   = ST_DEAD;
          tgt_n  = ST_ON;
          dcnt_n = dload;
        end
        default: st_n = ST_IDLE;
      endcase
    end
  end

  // Gate pattern decoded from the next state so the outputs are registers.
  always_comb begin
    hs_n = 2'b00;
    ls_n = 2'b00;
    case (st_n)
      ST_ON: begin
        hs_n = dq_n ? 2'b01 : 2'b10;
        ls_n = dq_n ? 2'b10 : 2'b01;
      end
      ST_FAST: begin
        hs_n = dq_n ? 2'b10 : 2'b01;
        ls_n = dq_n ? 2'b01 : 2'b10;
      end
      ST_SLOW: hs_n = 2'b11;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_IDLE;
      tgt  <= ST_IDLE;
      dk   <= DK_SLOW;
      dq   <= 1'b0;
      pend <= 1'b0;
      dcnt <= '0;
      fcnt <= '0;
      hs_q <= 2'b00;
      ls_q <= 2'b00;
    end else begin
      st   <= st_n;
      tgt  <= tgt_n;
      dk   <= dk_n;
      dq   <= dq_n;
      pend <= pend_n;
      dcnt <= dcnt_n;
      fcnt <= fcnt_n;
      hs_q <= hs_n;
      ls_q <= ls_n;
    end
  end

  a_r11_no_shoot: assert property (@(posedge clk) disable iff (rst)
    (hs_q & ls_q) == 2'b00);

  a_r3_dead_all_off: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DEAD) |-> (hs_q == 2'b00 && ls_q == 2'b00));

  a_r10_force_low: assert property (@(posedge clk) disable iff (rst)
    all_off |=> (hs_q == 2'b00 && ls_q == 2'b00 && st == ST_IDLE));

  a_r2_on_holds: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ON && !hs_over && !all_off) |=> (st == ST_ON));

  a_r9_on_entry: assert property (@(posedge clk) disable iff (rst)
    $rose(st == ST_ON) |-> ($past(st) == ST_DEAD || $past(st) == ST_IDLE));

  a_r7_threshold_exit: assert property (@(posedge clk) disable iff (rst)
    (st == ST_FAST && dk == DK_MIXTH && ls_under && !all_off) |=> (st == ST_DEAD));

  a_r5_fast_keeps: assert property (@(posedge clk) disable iff (rst)
    (st == ST_FAST && dk == DK_FAST && !wrap && !pend && !all_off) |=> (st == ST_FAST));

  a_r6_fix_bound: assert property (@(posedge clk) disable iff (rst)
    (st == ST_FAST && dk == DK_MIXFIX) |-> (fcnt < fix_eff));

endmodule

// File: rtl/dual_bridge_chopper.sv
module dual_bridge_chopper
  import chop_pkg::*;
#(
  parameter int NPH     = 2,
  parameter int PER_W   = 8,
  parameter int DT_BASE = 4,
  parameter int FIX_W   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             all_off,
  input  logic [1:0]       decay_mode,
  input  logic             auto_en,
  input  logic [1:0]       slew,
  input  logic [FIX_W-1:0] fix_len,
  input  logic [NPH-1:0]   dir,
  input  logic [NPH-1:0]   limit_up,
  input  logic [NPH-1:0]   hs_over,
  input  logic [NPH-1:0]   ls_under,
  output logic [2*NPH-1:0] hs_gate,
  output logic [2*NPH-1:0] ls_gate
);
  logic   wrap;
  decay_e mode;

  assign mode = decay_e'(decay_mode);

  chop_period #(.PER_W(PER_W)) u_period (
    .clk  (clk),
    .rst  (rst),
    .wrap (wrap)
  );

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    chop_phase #(.DT_BASE(DT_BASE), .FIX_W(FIX_W)) u_phase (
      .clk      (clk),
      .rst      (rst),
      .all_off  (all_off),
      .wrap     (wrap),
      .mode     (mode),
      .auto_en  (auto_en),
      .slew     (slew),
      .fix_len  (fix_len),
      .dir      (dir[p]),
      .limit_up (limit_up[p]),
      .hs_over  (hs_over[p]),
      .ls_under (ls_under[p]),
      .hs_q     (hs_gate[2*p+1 : 2*p]),
      .ls_q     (ls_gate[2*p+1 : 2*p])
    );
  end

endmodule

// File: tb/dual_bridge_chopper_tb.sv
`timescale 1ns/1ps
module dual_bridge_chopper_tb;
  localparam int NPH = 2, PER_W = 7, DT_BASE = 4, FIX_W = 4;
  localparam int PERIOD = 1 << PER_W;
  localparam logic [3:0] OFF = 4'b0000, SLOWP = 4'b1010;

  logic clk = 1'b0, rst = 1'b1, all_off = 1'b0, auto_en = 1'b0;
  logic [1:0] decay_mode = 2'b00, slew = 2'b00;
  logic [FIX_W-1:0] fix_len = '0;
  logic [NPH-1:0] dir = '0, limit_up = '0, hs_over = '0, ls_under = '0;
  logic [2*NPH-1:0] hs_gate, ls_gate;

  int total = 0, fails = 0, cyc = 0;

  always #4 clk = ~clk;

  dual_bridge_chopper #(.NPH(NPH), .PER_W(PER_W), .DT_BASE(DT_BASE), .FIX_W(FIX_W)) u_dut (
    .clk(clk), .rst(rst), .all_off(all_off), .decay_mode(decay_mode), .auto_en(auto_en),
    .slew(slew), .fix_len(fix_len), .dir(dir), .limit_up(limit_up), .hs_over(hs_over),
    .ls_under(ls_under), .hs_gate(hs_gate), .ls_gate(ls_gate)
  );

  // Pattern {HS_A, LS_A, HS_B, LS_B} of one phase.
  function automatic logic [3:0] obs(input int p);
    return {hs_gate[2*p], ls_gate[2*p], hs_gate[2*p+1], ls_gate[2*p+1]};
  endfunction
  function automatic logic [3:0] on_pat(input logic d);
    return d ? 4'b1001 : 4'b0110;
  endfunction
  function automatic logic [3:0] fast_pat(input logic d);
    return d ? 4'b0110 : 4'b1001;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
  endtask

  task automatic count_run(input logic [3:0] pat, output int n);
    n = 0;
    while (obs(0) == pat && n < 400) begin
      n++;
      step();
    end
  endtask

  task automatic wait_off();
    int k = 0;
    while (obs(0) != OFF && k < 400) begin
      k++;
      step();
    end
  endtask

  // Waits for the next on phase, checking the dead interval in front of it.
  task automatic sync_on(input bit first, input logic d, input int dl);
    int n;
    wait_off();
    count_run(OFF, n);
    chk(obs(0) == on_pat(d), "R2 on pattern", obs(0), on_pat(d));
    if (first) chk(n > 64, "R1 low until first wrap", n, 65);
    else       chk(n == dl, "R9 dead before new on phase", n, dl);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    bit first = 1'b1;
    int n, dl, fe, t0;
    logic [1:0] eff;
    repeat (3) step();
    chk(hs_gate == '0 && ls_gate == '0, "R1 gates low in reset", {hs_gate, ls_gate}, 0);
    rst = 1'b0;
    step();
    chk(hs_gate == '0 && ls_gate == '0, "R1 gates low after reset", {hs_gate, ls_gate}, 0);

    for (int s = 0; s < 4; s++)
      for (int m = 0; m < 4; m++)
        for (int a = 0; a < 2; a++)
          for (int u = 0; u < 2; u++)
            for (int d = 0; d < 2; d++) begin
              slew       = 2'(s);
              decay_mode = 2'(m);
              auto_en    = 1'(a);
              limit_up   = {NPH{1'(u)}};
              dir        = {NPH{1'(d)}};
              fix_len    = (s == 0) ? FIX_W'(0) : FIX_W'(7);
              fe         = (s == 0) ? 1 : 7;
              dl         = DT_BASE << s;
              if (a == 0) eff = 2'(m);
              else if (u == 1) eff = 2'b00;
              else eff = (m == 0) ? 2'b01 : 2'(m);

              sync_on(first, 1'(d), dl);
              first = 1'b0;
              for (int k = 0; k < 3; k++) begin
                step();
                chk(obs(0) == on_pat(1'(d)), "R2 on holds", obs(0), on_pat(1'(d)));
                chk(obs(1) == obs(0), "R2 phase 1 mapping", obs(1), obs(0));
              end
              hs_over = '1;
              step();
              hs_over = '0;
              count_run(OFF, n);
              chk(n == dl, "R3 dead after on", n, dl);
              case (eff)
                2'b00: chk(obs(0) == SLOWP, a ? "R8 auto slow" : "R4 slow pattern", obs(0), SLOWP);
                2'b01: begin
                  chk(obs(0) == fast_pat(1'(d)), a ? "R8 auto fast" : "R5 fast pattern",
                      obs(0), fast_pat(1'(d)));
                  ls_under = '1;
                  for (int k = 0; k < 4; k++) begin
                    step();
                    chk(obs(0) == fast_pat(1'(d)), "R5 under-run ignored", obs(0), fast_pat(1'(d)));
                  end
                  ls_under = '0;
                end
                2'b10: begin
                  count_run(fast_pat(1'(d)), n);
                  chk(n == fe, "R6 fixed fast length", n, fe);
                  count_run(OFF, n);
                  chk(n == dl, "R6 dead before slow", n, dl);
                  chk(obs(0) == SLOWP, "R6 slow after fast", obs(0), SLOWP);
                end
                default: begin
                  for (int k = 0; k < 5; k++) begin
                    chk(obs(0) == fast_pat(1'(d)), "R7 fast until under-run", obs(0), fast_pat(1'(d)));
                    step();
                  end
                  ls_under = '1;
                  step();
                  ls_under = '0;
                  count_run(OFF, n);
                  chk(n == dl, "R7 dead before slow", n, dl);
                  chk(obs(0) == SLOWP, "R7 slow after under-run", obs(0), SLOWP);
                end
              endcase
            end

    // Forced off, then restart from idle at the next wrap.
    slew = 2'd1; decay_mode = 2'b01; auto_en = 1'b0; dir = '1; limit_up = '0;
    dl = DT_BASE << 1;
    sync_on(1'b0, 1'b1, dl);
    t0 = cyc;
    step(); step();
    all_off = 1'b1;
    step();
    chk(hs_gate == '0 && ls_gate == '0, "R10 forced low", {hs_gate, ls_gate}, 0);
    step();
    chk(hs_gate == '0 && ls_gate == '0, "R10 held low", {hs_gate, ls_gate}, 0);
    all_off = 1'b0;
    step();
    count_run(OFF, n);
    chk(obs(0) == on_pat(1'b1), "R10 restart on pattern", obs(0), on_pat(1'b1));
    chk(cyc - t0 == PERIOD - dl, "R10 restart at wrap without dead", cyc - t0, PERIOD - dl);
    step();
    chk((hs_gate & ls_gate) == '0, "R11 no shoot-through", hs_gate & ls_gate, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule